// File: doc/BRIEF.md
# SPI Configuration Programming Sequencer

This block is a bus master that writes a configuration image into a programmable target device over SPI. It needs no processor. One pulse on `start` runs a fixed command script. The script puts the target into configuration mode and clears the target's storage. It then resets the target's write address and sends the image in 16-byte pages. After the last page it issues the finishing command, then repeats a refresh until the target's status word reports a healthy configured state. Each waiting step reads status in a loop with a retry limit. Failures after the storage is programmed end with a recovery sequence: clear the storage, wait until the target is idle, then refresh.

The image arrives as a byte stream with a valid/ready handshake. Its total length in bytes is sampled when `start` is accepted. The SPI link uses mode 0: the clock is low at idle, data is driven while the clock is low, and the target samples on the rising edge. The SPI clock divider is derived from the system clock frequency so that the serial clock never exceeds 66 MHz. Every wait after a command is given in microseconds and converted to clock cycles by parameter.

The result is a one-cycle `done` pulse on success. On failure, `err` is raised together with a code that identifies the failure. Both `err` and the code hold until the next accepted start.

Top module: `cfg_spi_loader`

## Requirements
- R1: While reset is held and after it is released, `spi_cs_n` is 1, `spi_sclk` is 0, and `done`, `err`, `err_code` and `img_ready` are all 0.
- R2: The SPI link works in mode 0 and sends MSB first. `spi_sclk` is 0 whenever `spi_cs_n` is 1, and `spi_mosi` does not change on a rising SCLK edge. Chip select is low for the whole of each frame and goes high between frames.
- R3: Every command is 4 bytes, sent opcode first. The commands are:
  - enable: C6 08 00 00
  - erase: 0E 04 00 00
  - address reset: 46 00 00 00
  - page write: 70 00 00 01
  - finish: 5E 00 00 00
  - status read: 3C 00 00 00
  - refresh: 79 00 00 00
- R4: A run starts with the enable frame and then the erase frame. Status is then read until bit 12 (busy) is 0. If bit 13 (fail) is 1 in that word, the run ends with code 2 and sends no further frames. Otherwise the address reset frame follows.
- R5: A status read is a single 8-byte frame. It carries the 4 command bytes and then 4 bytes clocked in from `spi_miso`, most significant byte first. MOSI is 0 during those 4 input bytes.
- R6: An image of N bytes, with N a multiple of 16, goes out as N/16 frames of 20 bytes. Each frame is the page write command followed by 16 stream bytes in arrival order. A byte is taken only on a cycle where `img_valid` and `img_ready` are both 1. When N is 0, no page frames are sent.
- R7: If the length is not a multiple of 16 (`img_len[3:0]` is not 0), the cycle after start shows `err`=1 and `err_code`=5, and no frame is sent.
- R8: If POLL_MAX status reads in a row all show busy, the run ends with code 1. No further frames are sent.
- R9: After the last page, the finish frame is sent and status is polled until the target is not busy. If bit 8 (done) is 0 in that word, recovery runs: erase, a busy poll, then refresh. The run then ends with code 3.
- R10: Each refresh is followed by a status read. The read succeeds when busy is 0, done is 1 and bits 25:23 are 0. On success `done` pulses for one cycle, with `err` at 0. After REFRESH_MAX failed reads, recovery runs and the run ends with code 4.
- R11: Chip select stays high for at least the configured wait after three kinds of frame:
  - the enable frame: T_SHORT_US
  - each page frame: T_PAGE_US
  - each refresh frame: T_REFRESH_US
- R12: A start pulse during a run is ignored. A start that is accepted clears `err` and `err_code` in the next cycle. `err` is 1 exactly when `err_code` is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when the block is idle |
| img_len | input | LEN_W | Image length in bytes, sampled when start is accepted |
| img_data | input | 8 | Image stream byte |
| img_valid | input | 1 | Image byte is present |
| img_ready | output | 1 | The block takes the byte this cycle |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the target |
| spi_miso | input | 1 | SPI data from the target |
| done | output | 1 | One-cycle pulse on a successful run |
| err | output | 1 | Run failed; holds until the next accepted start |
| err_code | output | 3 | 0 none, 1 busy timeout, 2 erase failed, 3 done missing, 4 refresh exhausted, 5 bad length |

## Verification
The hardest paths to reach are the recovery paths. Each one needs the target to answer a particular status read, deep inside the script, with a chosen word. Refresh exhaustion, for example, needs the done bit set but a nonzero error field on every refresh read, followed by a busy answer inside the recovery poll. The bench runs a behavioural target on the SPI pins. The target holds a queue of status words, and each test fills the queue so that a given status read gets a given word. Unqueued reads return a healthy word. The position of the busy bit in the status word also exposes an inverted byte order on input.

// File: rtl/cfg_spi_loader.sv
module cfg_spi_loader #(
  parameter int CLK_FREQ_HZ  = 100_000_000,
  parameter int SCLK_MAX_HZ  = 66_000_000,
  parameter int T_SHORT_US   = 5,
  parameter int T_PAGE_US    = 200,
  parameter int T_REFRESH_US = 4800,
  parameter int POLL_MAX     = 128,
  parameter int REFRESH_MAX  = 16,
  parameter int LEN_W        = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic [7:0]       img_data,
  input  logic             img_valid,
  output logic             img_ready,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code
);

  localparam int CYC_US    = CLK_FREQ_HZ / 1_000_000;
  localparam int D_SHORT   = T_SHORT_US * CYC_US;
  localparam int D_PAGE    = T_PAGE_US * CYC_US;
  localparam int D_REFRESH = T_REFRESH_US * CYC_US;
  localparam int DLY_W     = $clog2(D_SHORT + D_PAGE + D_REFRESH + 2);
  localparam int HALF_RAW  = (CLK_FREQ_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int HALF      = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int DIV_W     = $clog2(HALF + 1);
  localparam int PC_W      = $clog2(POLL_MAX + 1);
  localparam int RC_W      = $clog2(REFRESH_MAX + 1);
  localparam int PG_W      = LEN_W - 4;

  localparam logic [2:0] E_BUSY = 3'd1, E_FAIL = 3'd2, E_NODONE = 3'd3,
                         E_REFR = 3'd4, E_LEN  = 3'd5;

  typedef enum logic [2:0] {OP_EN, OP_ER, OP_IA, OP_PI, OP_PD, OP_RS, OP_RF} op_t;
  typedef enum logic [3:0] {
    S_IDLE, S_EN, S_ER, S_PA, S_IA, S_PG, S_PD, S_PB, S_RF, S_RS, S_CE, S_PC, S_CR
  } st_t;
  typedef enum logic [2:0] {F_IDLE, F_LOAD, F_LO, F_HI, F_POST} fr_t;

  st_t             st;
  fr_t             fr_st;
  op_t             op;
  logic            fr_done, launch, data_byte;
  logic [4:0]      bidx, last_idx;
  logic [2:0]      bitc;
  logic [7:0]      sh, next_byte;
  logic [31:0]     rx;
  logic [DIV_W-1:0] div;
  logic [DLY_W-1:0] dly, post_cyc;
  logic [PG_W-1:0] pages;
  logic [PC_W-1:0] pcnt;
  logic [RC_W-1:0] rcnt;
  logic [2:0]      pend;

  wire s_busy = rx[12];
  wire s_dn   = rx[8];
  wire s_fail = rx[13];
  wire s_ok   = !rx[12] && rx[8] && (rx[25:23] == 3'd0);
  logic unused_bits;
  assign unused_bits = ^{rx[31:26], rx[22:14], rx[11:9], rx[7:0]};

  function automatic logic [7:0] cmd_byte(op_t o, logic [1:0] i);
    logic [31:0] w;
    case (o)
      OP_EN:   w = 32'hC608_0000;
      OP_ER:   w = 32'h0E04_0000;
      OP_IA:   w = 32'h4600_0000;
      OP_PI:   w = 32'h7000_0001;
      OP_PD:   w = 32'h5E00_0000;
      OP_RS:   w = 32'h3C00_0000;
      default: w = 32'h7900_0000;
    endcase
    return w[8*(3-i) +: 8];
  endfunction

  always_comb begin
    case (st)
      S_EN:                   op = OP_EN;
      S_ER, S_CE:             op = OP_ER;
      S_IA:                   op = OP_IA;
      S_PG:                   op = OP_PI;
      S_PD:                   op = OP_PD;
      S_RF, S_CR:             op = OP_RF;
      default:                op = OP_RS;
    endcase
  end

  assign last_idx  = (op == OP_PI) ? 5'd19 : (op == OP_RS) ? 5'd7 : 5'd3;
  assign post_cyc  = (op == OP_EN) ? DLY_W'(D_SHORT) :
                     (op == OP_PI) ? DLY_W'(D_PAGE)  :
                     (op == OP_RF) ? DLY_W'(D_REFRESH) : '0;
  assign data_byte = (bidx[4:2] != 3'd0) && (op == OP_PI);
  assign next_byte = (bidx[4:2] == 3'd0) ? cmd_byte(op, bidx[1:0]) :
                     data_byte ? img_data : 8'h00;
  assign img_ready = (fr_st == F_LOAD) && data_byte;
  assign spi_mosi  = sh[7];
  assign launch    = (st != S_IDLE) && (fr_st == F_IDLE) && !fr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_st <= F_IDLE; spi_cs_n <= 1'b1; spi_sclk <= 1'b0; sh <= '0;
      bitc <= '0; bidx <= '0; div <= '0; dly <= '0; rx <= '0; fr_done <= 1'b0;
    end else begin
      fr_done <= 1'b0;
      case (fr_st)
        F_IDLE: if (launch) begin
          spi_cs_n <= 1'b0; bidx <= '0; fr_st <= F_LOAD;
        end
        F_LOAD: if (!data_byte || img_valid) begin
          sh <= next_byte; bitc <= 3'd7; div <= DIV_W'(HALF - 1); fr_st <= F_LO;
        end
        F_LO: if (div == '0) begin
          spi_sclk <= 1'b1; rx <= {rx[30:0], spi_miso};
          div <= DIV_W'(HALF - 1); fr_st <= F_HI;
        end else div <= div - 1'b1;
        F_HI: if (div == '0) begin
          spi_sclk <= 1'b0;
          if (bitc == 3'd0) begin
            if (bidx == last_idx) begin
              spi_cs_n <= 1'b1; dly <= post_cyc; fr_st <= F_POST;
            end else begin
              bidx <= bidx + 1'b1; fr_st <= F_LOAD;
            end
          end else begin
            sh <= {sh[6:0], 1'b0}; bitc <= bitc - 1'b1;
            div <= DIV_W'(HALF - 1); fr_st <= F_LO;
          end
        end else div <= div - 1'b1;
        default: if (dly == '0) begin
          fr_done <= 1'b1; fr_st <= F_IDLE;
        end else dly <= dly - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; err <= 1'b0; err_code <= '0;
      pend <= '0; pages <= '0; pcnt <= '0; rcnt <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          if (img_len[3:0] != 4'd0) begin
            err <= 1'b1; err_code <= E_LEN;
          end else begin
            err <= 1'b0; err_code <= '0; pages <= img_len[LEN_W-1:4]; st <= S_EN;
          end
        end
      end else if (fr_done) begin
        case (st)
          S_EN: st <= S_ER;
          S_ER: begin st <= S_PA; pcnt <= '0; end
          S_PA:
            if (!s_busy) begin
              if (s_fail) begin st <= S_IDLE; err <= 1'b1; err_code <= E_FAIL; end
              else st <= S_IA;
            end else if (pcnt == PC_W'(POLL_MAX - 1)) begin
              st <= S_IDLE; err <= 1'b1; err_code <= E_BUSY;
            end else pcnt <= pcnt + 1'b1;
          S_IA: st <= (pages == '0) ? S_PD : S_PG;
          S_PG: begin
            pages <= pages - 1'b1;
            if (pages == PG_W'(1)) st <= S_PD;
          end
          S_PD: begin st <= S_PB; pcnt <= '0; end
          S_PB:
            if (!s_busy) begin
              if (s_dn) begin st <= S_RF; rcnt <= '0; end
              else begin pend <= E_NODONE; st <= S_CE; end
            end else if (pcnt == PC_W'(POLL_MAX - 1)) begin
              st <= S_IDLE; err <= 1'b1; err_code <= E_BUSY;
            end else pcnt <= pcnt + 1'b1;
          S_RF: st <= S_RS;
          S_RS:
            if (s_ok) begin st <= S_IDLE; done <= 1'b1; end
            else if (rcnt == RC_W'(REFRESH_MAX - 1)) begin pend <= E_REFR; st <= S_CE; end
            else begin rcnt <= rcnt + 1'b1; st <= S_RF; end
          S_CE: begin st <= S_PC; pcnt <= '0; end
          S_PC:
            if (!s_busy) st <= S_CR;
            else if (pcnt == PC_W'(POLL_MAX - 1)) begin
              st <= S_IDLE; err <= 1'b1; err_code <= pend;
            end else pcnt <= pcnt + 1'b1;
          default: begin st <= S_IDLE; err <= 1'b1; err_code <= pend; end
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_spi_loader_chk.sv
module cfg_spi_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_sclk,
  input logic       spi_cs_n,
  input logic       spi_mosi,
  input logic       img_ready,
  input logic       done,
  input logic       err,
  input logic [2:0] err_code
);

  a_r2_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  a_r2_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  a_r6_ready_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready |-> !spi_cs_n);

  a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_without_error: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);

  a_r12_flag_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    err == (err_code != 3'd0));

endmodule

bind cfg_spi_loader cfg_spi_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .img_ready(img_ready), .done(done), .err(err),
  .err_code(err_code)
);

// File: tb/cfg_spi_loader_bench.sv
module cfg_spi_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ = 10_000_000;
  localparam int TS = 1, TP = 3, TR = 5;
  localparam int PMAX = 6, RMAX = 3;
  localparam int D_S = TS * FREQ / 1_000_000;
  localparam int D_P = TP * FREQ / 1_000_000;
  localparam int D_R = TR * FREQ / 1_000_000;
  localparam int LW = 12;
  localparam logic [31:0] ST_OK = 32'h0000_0100, ST_BUSY = 32'h0000_1000,
                          ST_FAIL = 32'h0000_2000, ST_NODONE = 32'h0000_0000,
                          ST_EFLD = 32'h0080_0100, ST_BDN = 32'h0000_1100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] img_len = '0;
  logic [7:0] img_data = '0;
  logic img_valid = 1'b0, spi_miso = 1'b0;
  logic img_ready, spi_sclk, spi_cs_n, spi_mosi, done, err;
  logic [2:0] err_code;

  cfg_spi_loader #(.CLK_FREQ_HZ(FREQ), .T_SHORT_US(TS), .T_PAGE_US(TP),
    .T_REFRESH_US(TR), .POLL_MAX(PMAX), .REFRESH_MAX(RMAX), .LEN_W(LW))
  u_cfg_spi_loader (.clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .img_data(img_data), .img_valid(img_valid), .img_ready(img_ready),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .done(done), .err(err), .err_code(err_code));

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  logic [7:0] got_b[$], exp_b[$], cur_fr[$], img_q[$];
  int got_len[$], exp_len[$];
  logic [31:0] stat_q[$];
  logic [31:0] cur_st = '0;
  logic [7:0] shb = '0, last_op = '0;
  int nb = 0, gap = 0;
  bit have_prev = 0, rx_loaded = 0, prev_cs = 1, prev_sclk = 0, took = 0, chk_on = 0;
  logic [2:0] exp_code = '0;

  task automatic bad(string req, string what, int act, int expv);
    n_bad++;
    $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
  endtask

  // target model, stream source and per-clock comparison
  initial forever begin
    @(negedge clk);
    cyc++;
    if (took) img_q.delete(0);
    img_valid = (img_q.size() > 0) && (cyc % 5 != 3);
    img_data  = img_valid ? img_q[0] : 8'h00;
    took = img_valid && img_ready;
    if (rst_n) begin
      if (prev_cs && !spi_cs_n) begin
        if (have_prev) begin
          int req = (last_op == 8'hC6) ? D_S : (last_op == 8'h70) ? D_P :
                    (last_op == 8'h79) ? D_R : 0;
          n_vec++;
          if (gap < req) bad("R11", "cs high gap", gap, req);
        end
        cur_fr.delete(); nb = 0; rx_loaded = 0;
      end
      if (!spi_cs_n) begin
        if (!prev_sclk && spi_sclk) begin
          shb = {shb[6:0], spi_mosi}; nb++;
          if (nb % 8 == 0) cur_fr.push_back(shb);
        end
        if (!spi_sclk) begin
          if (nb == 32 && cur_fr.size() > 0 && cur_fr[0] == 8'h3C && !rx_loaded) begin
            cur_st = (stat_q.size() > 0) ? stat_q.pop_front() : ST_OK;
            rx_loaded = 1;
          end
          spi_miso = (rx_loaded && nb >= 32 && nb < 64) ? cur_st[63 - nb] : 1'b0;
        end
      end
      if (!prev_cs && spi_cs_n) begin
        got_len.push_back(cur_fr.size());
        foreach (cur_fr[k]) got_b.push_back(cur_fr[k]);
        last_op = (cur_fr.size() > 0) ? cur_fr[0] : 8'h00;
        have_prev = 1; gap = 0;
      end
      if (spi_cs_n) gap++;
      prev_cs = spi_cs_n; prev_sclk = spi_sclk;
      n_vec++;
      if (spi_cs_n && spi_sclk) bad("R2", "sclk while deselected", 1, 0);
      if (chk_on) begin
        n_vec++;
        if (done && (exp_code != 3'd0 || err)) bad("R10", "unexpected done", 1, 0);
        if (err && err_code != exp_code) bad("R12", "err_code", err_code, exp_code);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic add_cmd(logic [31:0] w);
    exp_len.push_back(4);
    for (int i = 3; i >= 0; i--) exp_b.push_back(w[8*i +: 8]);
  endtask
  task automatic add_rs();
    exp_len.push_back(8);
    exp_b.push_back(8'h3C);
    for (int i = 0; i < 7; i++) exp_b.push_back(8'h00);
  endtask
  task automatic add_page(int seed);
    exp_len.push_back(20);
    exp_b.push_back(8'h70); exp_b.push_back(8'h00);
    exp_b.push_back(8'h00); exp_b.push_back(8'h01);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b = 8'((seed + i) * 37 + 11);
      exp_b.push_back(b); img_q.push_back(b);
    end
  endtask

  task automatic cmp_frames(string req);
    int go = 0, eo = 0;
    n_vec++;
    if (got_len.size() != exp_len.size())
      bad(req, "frame count", got_len.size(), exp_len.size());
    for (int i = 0; i < exp_len.size() && i < got_len.size(); i++) begin
      bit ok = (got_len[i] == exp_len[i]);
      int bi = 0;
      if (ok)
        for (int j = 0; j < exp_len[i]; j++)
          if (ok && got_b[go + j] != exp_b[eo + j]) begin ok = 0; bi = j; end
      n_vec++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s frame %0d: actual len %0d byte%0d 0x%0h expected len %0d byte%0d 0x%0h",
                 req, i, got_len[i], bi, got_b[go + bi], exp_len[i], bi, exp_b[eo + bi]);
        break;
      end
      go += got_len[i]; eo += exp_len[i];
    end
  endtask

  task automatic run_case(string req, int len, logic [2:0] code, bit poke);
    @(negedge clk);
    got_b.delete(); got_len.delete(); have_prev = 0; chk_on = 0; exp_code = code;
    img_len = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_vec++;
    if (code == 3'd5) begin
      if (!err || err_code != 3'd5) bad("R7", "bad length flag", {err, err_code}, {1'b1, 3'd5});
    end else if (err) bad("R12", "err cleared by start", err, 0);
    chk_on = 1;
    for (int i = 0; i < 40000 && !(done || err); i++) begin
      @(negedge clk);
      if (poke && i == 60) begin
        img_len = LW'(7); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    n_vec++;
    if (code == 3'd0) begin
      if (!done || err) bad(req, "done at end", {done, err}, 2'b10);
      @(negedge clk);
      n_vec++;
      if (done) bad("R10", "done width", 1, 0);
    end else if (!err || err_code != code) bad(req, "error code", err_code, code);
    repeat (4) @(negedge clk);
    chk_on = 0;
    cmp_frames(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (!spi_cs_n || spi_sclk || done || err || err_code != 0 || img_ready)
      bad("R1", "in reset", {spi_cs_n, spi_sclk, done, err, err_code, img_ready}, 8'b1000_0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (!spi_cs_n || spi_sclk || done || err || err_code != 0 || img_ready)
      bad("R1", "after reset", {spi_cs_n, spi_sclk, done, err, err_code, img_ready}, 8'b1000_0000);

    // R7 malformed length: no frames
    exp_b.delete(); exp_len.delete();
    run_case("R7", 20, 3'd5, 0);

    // R3 R4 R5 R6 R10 R12: three pages, busy polls, one failed refresh, mid-run start ignored
    exp_b.delete(); exp_len.delete(); stat_q.delete();
    stat_q = '{ST_BUSY, ST_BUSY, ST_OK, ST_BUSY, ST_OK, ST_BDN, ST_OK};
    add_cmd(32'hC608_0000); add_cmd(32'h0E04_0000); add_rs(); add_rs(); add_rs();
    add_cmd(32'h4600_0000); add_page(0); add_page(16); add_page(32);
    add_cmd(32'h5E00_0000); add_rs(); add_rs();
    add_cmd(32'h7900_0000); add_rs(); add_cmd(32'h7900_0000); add_rs();
    run_case("R6/R10", 48, 3'd0, 1);

    // R6 zero-length image
    exp_b.delete(); exp_len.delete(); stat_q.delete();
    add_cmd(32'hC608_0000); add_cmd(32'h0E04_0000); add_rs(); add_cmd(32'h4600_0000);
    add_cmd(32'h5E00_0000); add_rs(); add_cmd(32'h7900_0000); add_rs();
    run_case("R6", 0, 3'd0, 0);

    // R4 fail bit after erase
    exp_b.delete(); exp_len.delete(); stat_q.delete();
    stat_q = '{ST_FAIL};
    add_cmd(32'hC608_0000); add_cmd(32'h0E04_0000); add_rs();
    run_case("R4", 32, 3'd2, 0);
    img_q.delete();

    // R8 busy never clears
    exp_b.delete(); exp_len.delete(); stat_q.delete();
    add_cmd(32'hC608_0000); add_cmd(32'h0E04_0000);
    for (int i = 0; i < PMAX; i++) begin stat_q.push_back(ST_BUSY); add_rs(); end
    run_case("R8", 0, 3'd1, 0);

    // R9 done bit missing after finish
    exp_b.delete(); exp_len.delete(); stat_q.delete();
    stat_q = '{ST_OK, ST_NODONE, ST_BUSY};
    add_cmd(32'hC608_0000); add_cmd(32'h0E04_0000); add_rs(); add_cmd(32'h4600_0000);
    add_page(100); add_cmd(32'h5E00_0000); add_rs();
    add_cmd(32'h0E04_0000); add_rs(); add_rs(); add_cmd(32'h7900_0000);
    run_case("R9", 16, 3'd3, 0);

    // R10 refresh exhausted (done set but error field nonzero)
    exp_b.delete(); exp_len.delete(); stat_q.delete();
    stat_q = '{ST_OK, ST_OK};
    add_cmd(32'hC608_0000); add_cmd(32'h0E04_0000); add_rs(); add_cmd(32'h4600_0000);
    add_cmd(32'h5E00_0000); add_rs();
    for (int i = 0; i < RMAX; i++) begin
      stat_q.push_back(ST_EFLD); add_cmd(32'h7900_0000); add_rs();
    end
    stat_q.push_back(ST_BUSY);
    add_cmd(32'h0E04_0000); add_rs(); add_rs(); add_cmd(32'h7900_0000);
    run_case("R10", 0, 3'd4, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule